// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Controller

This block gathers a 32-bit vector of hardware interrupt sources into one shared pending word, applies a shared mask, and turns what remains into a 4-bit processor interrupt level from 0 to 15 for each of up to four CPUs. Several sources share one level through a fixed table. A target register picks the one CPU that receives the shared sources.

Each CPU also has private state. Fifteen software interrupts per CPU can be raised and dropped through that CPU's own set and clear ports, so one processor can signal another. Each CPU also has a private timer input that drives level 14. Every CPU output shows the highest level among its private sources and, for the target CPU only, the unmasked shared sources. One mask bit acts as a master switch that silences every output.

Software reaches all of this through a plain 32-bit word-addressed register port. Writes take effect at the clock edge. Reads are combinational. The level outputs are registered.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, the mask reads 32'hFFFF_FFFF, the target register reads 0, every CPU's software pending bits are 0, and every level output is 0.
- R2: A read of word 0 returns src_i as it is, before masking, restricted to the defined source bits 30..27, 22..14 and 13..0. Bits 31 and 26..23 read 0.
- R3: Ones written to word 3 set the matching mask bits, and ones written to word 2 clear them. Zero bits leave mask bits unchanged. Word 1 reads the mask, and writes to words 0 and 1 are ignored.
- R4: While mask bit 31 is set, every level output is 0, whatever else is pending.
- R5: An unmasked shared source maps to a level as follows. Bits 0..6 and 7..13 (two buses, levels 0..6) map to 2, 3, 5, 7, 9, 11, 13. Bit 18 maps to 4, bit 16 to 6, bit 20 to 8, bit 21 to 9, bit 19 to 10, bit 22 to 11, bits 14 and 15 to 12, bit 17 to 13, and bits 27..30 to 15. Bits with no entry give level 0.
- R6: Shared sources reach only the CPU named by the low bits of the target register at word 4. A write naming an index at or above the CPU count is ignored.
- R7: CPU c has a pending word at word 8+4c, a clear port at 8+4c+1 and a set port at 8+4c+2. Software interrupt n (1..15) sits at bit 16+n. Writing ones to the set port raises those bits, and writing ones to the clear port drops them. Bits 16..0 cannot be written.
- R8: tick_i[c] appears as bit 7 of CPU c's pending word and gives level 14 on CPU c only, whoever the target is.
- R9: level_o[4c+3:4c] shows, one clock after its inputs, the highest level among CPU c's software bits (level n), its timer (14) and, when c is the target, the shared level.
- R10: Reads of write-only ports and of unmapped words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| src_i | input | 32 | Shared hardware interrupt sources, already synchronised |
| tick_i | input | NCPU | Private timer interrupt per CPU |
| level_o | output | 4*NCPU | Registered interrupt level, 4 bits per CPU |

## Verification
Two things can fall in the same clock edge: a software-interrupt write to a CPU's set port and a rise of that CPU's private timer. The bench drives both in one cycle on CPU 0. It expects level 14 to appear the next cycle and level 3 to remain once the timer drops. In the same spirit, a master-mask write is placed on top of pending soft, timer and shared requests, and every output must fall to 0 together.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
  localparam int DW         = 32;
  localparam int LVL_W      = 4;
  localparam int SOFT_N     = 15;
  localparam int SOFT_LSB   = 17;
  localparam int TICK_BIT   = 7;
  localparam int MASTER_BIT = 31;
  localparam logic [LVL_W-1:0] TICK_LVL = 4'd14;
  localparam logic [DW-1:0] SRC_VALID = 32'h787F_FFFF;

  // word addresses
  localparam int A_GPEND    = 0;
  localparam int A_GMASK    = 1;
  localparam int A_GMCLR    = 2;
  localparam int A_GMSET    = 3;
  localparam int A_GTGT     = 4;
  localparam int A_CPU_BASE = 8;
  localparam int CPU_STRIDE = 4;
  localparam int O_PEND     = 0;
  localparam int O_CLR      = 1;
  localparam int O_SET      = 2;

  function automatic logic [LVL_W-1:0] src_level(input int b);
    int idx;
    logic [LVL_W-1:0] l;
    l = '0;
    if (b <= 13) begin
      idx = b % 7;
      l = (idx == 0) ? 4'd2 : 4'(2 * idx + 1);
    end else begin
      case (b)
        14, 15:         l = 4'd12;
        16:             l = 4'd6;
        17:             l = 4'd13;
        18:             l = 4'd4;
        19:             l = 4'd10;
        20:             l = 4'd8;
        21:             l = 4'd9;
        22:             l = 4'd11;
        27, 28, 29, 30: l = 4'd15;
        default:        l = 4'd0;
      endcase
    end
    return l;
  endfunction

  function automatic logic [LVL_W-1:0] top_level(input logic [DW-1:0] v);
    logic [LVL_W-1:0] m;
    m = '0;
    for (int b = 0; b < DW; b++) begin
      if (v[b] && src_level(b) > m) m = src_level(b);
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_glb_regs.sv
module irq_glb_regs
  import irq_level_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CPU_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_mclr_i,
  input  logic             wr_mset_i,
  input  logic             wr_tgt_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    mask_o,
  output logic [CPU_W-1:0] target_o
);
  logic [DW-1:0]    mask_q, mask_d;
  logic [CPU_W-1:0] target_q;

  // clear wins over set if both strobes ever coincide
  always_comb begin
    mask_d = mask_q;
    if (wr_mset_i) mask_d = mask_d | wdata_i;
    if (wr_mclr_i) mask_d = mask_d & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '1;
      target_q <= '0;
    end else begin
      mask_q <= mask_d;
      if (wr_tgt_i && (int'(wdata_i[CPU_W-1:0]) < NCPU))
        target_q <= wdata_i[CPU_W-1:0];
    end
  end

  assign mask_o   = mask_q;
  assign target_o = target_q;
endmodule

// File: rtl/irq_soft_regs.sv
module irq_soft_regs
  import irq_level_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_set_i,
  input  logic              wr_clr_i,
  input  logic [SOFT_N-1:0] wbits_i,
  output logic [SOFT_N-1:0] soft_o
);
  logic [SOFT_N-1:0] soft_q, soft_d;

  always_comb begin
    soft_d = soft_q;
    if (wr_set_i) soft_d = soft_d | wbits_i;
    if (wr_clr_i) soft_d = soft_d & ~wbits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) soft_q <= '0;
    else         soft_q <= soft_d;
  end

  assign soft_o = soft_q;
endmodule

// File: rtl/irq_lvl_merge.sv
module irq_lvl_merge
  import irq_level_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SOFT_N-1:0] soft_i,
  input  logic              tick_i,
  input  logic [LVL_W-1:0]  shared_lvl_i,
  input  logic              is_target_i,
  input  logic              master_i,
  output logic [LVL_W-1:0]  level_o
);
  logic [LVL_W-1:0] soft_lvl, lvl_d, level_q;

  always_comb begin
    soft_lvl = '0;
    for (int i = 0; i < SOFT_N; i++) begin
      if (soft_i[i]) soft_lvl = 4'(i + 1);
    end
  end

  always_comb begin
    lvl_d = soft_lvl;
    if (tick_i && TICK_LVL > lvl_d) lvl_d = TICK_LVL;
    if (is_target_i && shared_lvl_i > lvl_d) lvl_d = shared_lvl_i;
    if (master_i) lvl_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= lvl_d;
  end

  assign level_o = level_q;
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_level_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [31:0]             src_i,
  input  logic [NCPU-1:0]         tick_i,
  output logic [NCPU*LVL_W-1:0]   level_o
);
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam logic [ADDR_W-1:0] AD_GPEND = ADDR_W'(A_GPEND);
  localparam logic [ADDR_W-1:0] AD_GMASK = ADDR_W'(A_GMASK);
  localparam logic [ADDR_W-1:0] AD_GMCLR = ADDR_W'(A_GMCLR);
  localparam logic [ADDR_W-1:0] AD_GMSET = ADDR_W'(A_GMSET);
  localparam logic [ADDR_W-1:0] AD_GTGT  = ADDR_W'(A_GTGT);

  logic [DW-1:0]          mask_q;
  logic [CPU_W-1:0]       target_q;
  logic [NCPU*SOFT_N-1:0] soft_all;
  logic [NCPU*DW-1:0]     cpu_words;
  logic [NCPU-1:0]        cpu_rd_hit;
  logic [LVL_W-1:0]       shared_lvl;

  irq_glb_regs #(.NCPU(NCPU), .CPU_W(CPU_W)) u_glb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_mclr_i (we_i && addr_i == AD_GMCLR),
    .wr_mset_i (we_i && addr_i == AD_GMSET),
    .wr_tgt_i  (we_i && addr_i == AD_GTGT),
    .wdata_i   (wdata_i),
    .mask_o    (mask_q),
    .target_o  (target_q)
  );

  assign shared_lvl = top_level(src_i & SRC_VALID & ~mask_q);

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    localparam logic [ADDR_W-1:0] AD_PEND = ADDR_W'(A_CPU_BASE + CPU_STRIDE * c + O_PEND);
    localparam logic [ADDR_W-1:0] AD_CLR  = ADDR_W'(A_CPU_BASE + CPU_STRIDE * c + O_CLR);
    localparam logic [ADDR_W-1:0] AD_SET  = ADDR_W'(A_CPU_BASE + CPU_STRIDE * c + O_SET);
    logic [SOFT_N-1:0] soft_c;

    irq_soft_regs u_soft (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_set_i (we_i && addr_i == AD_SET),
      .wr_clr_i (we_i && addr_i == AD_CLR),
      .wbits_i  (wdata_i[DW-1:SOFT_LSB]),
      .soft_o   (soft_c)
    );

    irq_lvl_merge u_merge (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .soft_i       (soft_c),
      .tick_i       (tick_i[c]),
      .shared_lvl_i (shared_lvl),
      .is_target_i  (target_q == CPU_W'(c)),
      .master_i     (mask_q[MASTER_BIT]),
      .level_o      (level_o[c*LVL_W +: LVL_W])
    );

    assign soft_all[c*SOFT_N +: SOFT_N] = soft_c;
    assign cpu_words[c*DW +: DW] = {soft_c, 1'b0, 8'b0, tick_i[c], 7'b0};
    assign cpu_rd_hit[c] = (addr_i == AD_PEND);
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AD_GPEND)      rdata_o = src_i & SRC_VALID;
    else if (addr_i == AD_GMASK) rdata_o = mask_q;
    else if (addr_i == AD_GTGT)  rdata_o = DW'(target_q);
    for (int c = 0; c < NCPU; c++) begin
      if (cpu_rd_hit[c]) rdata_o = cpu_words[c*DW +: DW];
    end
  end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
  import irq_level_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 5,
  parameter int CPU_W  = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [31:0]             wdata_i,
  input logic [NCPU-1:0]         tick_i,
  input logic [NCPU*LVL_W-1:0]   level_o,
  input logic [DW-1:0]           mask_q,
  input logic [CPU_W-1:0]        target_q,
  input logic [NCPU*SOFT_N-1:0]  soft_all
);
  assert_mask_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(A_GMSET)) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  assert_mask_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(A_GMCLR)) |=> ((mask_q & $past(wdata_i)) == '0));

  assert_master_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q[MASTER_BIT] |=> (level_o == '0));

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    assert_soft_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(A_CPU_BASE + CPU_STRIDE * c + O_SET)) |=>
      ((soft_all[c*SOFT_N +: SOFT_N] & $past(wdata_i[31:SOFT_LSB])) == $past(wdata_i[31:SOFT_LSB])));

    assert_soft_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(A_CPU_BASE + CPU_STRIDE * c + O_CLR)) |=>
      ((soft_all[c*SOFT_N +: SOFT_N] & $past(wdata_i[31:SOFT_LSB])) == '0));

    assert_nontarget_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((target_q != CPU_W'(c)) && (soft_all[c*SOFT_N +: SOFT_N] == '0) && !tick_i[c]) |=>
      (level_o[c*LVL_W +: LVL_W] == '0));
  end
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NCPU(NCPU), .ADDR_W(ADDR_W), .CPU_W(CPU_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .tick_i   (tick_i),
  .level_o  (level_o),
  .mask_q   (mask_q),
  .target_q (target_q),
  .soft_all (soft_all)
);

// File: tb/sim_irq_level_ctrl.sv
`timescale 1ns/1ps
module sim_irq_level_ctrl;
  localparam int NCPU = 4;
  localparam int AW   = 5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0;
  logic [AW-1:0]     addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [31:0]       src_i = '0;
  logic [NCPU-1:0]   tick_i = '0;
  logic [NCPU*4-1:0] level_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  irq_level_ctrl #(.NCPU(NCPU), .ADDR_W(AW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .src_i(src_i),
    .tick_i(tick_i), .level_o(level_o)
  );

  // {src, expected level on target CPU 0}
  localparam logic [35:0] VEC [19] = '{
    {32'h0000_0001, 4'd2},  {32'h0000_0040, 4'd13}, {32'h0000_0080, 4'd2},
    {32'h0000_0400, 4'd7},  {32'h0000_2000, 4'd13}, {32'h0000_4000, 4'd12},
    {32'h0000_8000, 4'd12}, {32'h0001_0000, 4'd6},  {32'h0002_0000, 4'd13},
    {32'h0004_0000, 4'd4},  {32'h0008_0000, 4'd10}, {32'h0010_0000, 4'd8},
    {32'h0020_0000, 4'd9},  {32'h0040_0000, 4'd11}, {32'h0800_0000, 4'd15},
    {32'h4000_0000, 4'd15}, {32'h0005_0008, 4'd7},  {32'h0100_0000, 4'd0},
    {32'h8000_0000, 4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lvl(input int c);
    return 32'(level_o[c*4 +: 4]);
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = AW'(a);
    #1 d = rdata_o;
  endtask

  task automatic settle;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(1, r); chk("R1 mask", r, 32'hFFFF_FFFF);
    rd(4, r); chk("R1 target", r, 32'h0);
    for (int c = 0; c < NCPU; c++) begin
      rd(8 + 4*c, r); chk("R1 cpu pending", r, 32'h0);
      chk("R1 level", lvl(c), 32'h0);
    end

    // R2 raw pending, masked sources still readable and not delivered
    src_i = 32'hFFFF_FFFF;
    rd(0, r); chk("R2 raw pending", r, 32'h787F_FFFF);
    settle(); chk("R2 masked level", lvl(0), 32'h0);
    src_i = 32'h0;

    // R3 mask ports
    wr(2, 32'h7FFF_FFFF); rd(1, r); chk("R3 clear port", r, 32'h8000_0000);
    wr(1, 32'h0);         rd(1, r); chk("R3 mask word read-only", r, 32'h8000_0000);
    wr(0, 32'h0);         rd(1, r); chk("R3 pending write ignored", r, 32'h8000_0000);
    wr(3, 32'h0000_0100); rd(1, r); chk("R3 set port", r, 32'h8000_0100);
    wr(2, 32'h8000_0100); rd(1, r); chk("R3 clear to zero", r, 32'h0);

    // R5 source table walk on target CPU 0
    for (int i = 0; i < 19; i++) begin
      @(negedge clk_i);
      src_i = VEC[i][35:4];
      settle();
      chk($sformatf("R5 vector %0d", i), lvl(0), 32'(VEC[i][3:0]));
    end
    src_i = 32'h0;

    // R6 target steering
    wr(4, 32'd2);
    src_i = 32'h0008_0000;
    settle();
    chk("R6 target cpu2", lvl(2), 32'd10);
    chk("R6 non-target cpu0", lvl(0), 32'd0);
    rd(4, r); chk("R6 target read", r, 32'd2);
    wr(4, 32'd1); settle();
    chk("R6 retarget cpu1", lvl(1), 32'd10);
    chk("R6 old target cpu2", lvl(2), 32'd0);
    src_i = 32'h0; settle();

    // R7 soft interrupts on CPU 1 (pending 12, clear 13, set 14)
    wr(14, 32'h0020_0000); settle();
    chk("R7 soft n5 level", lvl(1), 32'd5);
    rd(12, r); chk("R7 soft pending", r, 32'h0020_0000);
    wr(14, 32'h0001_FFFF); rd(12, r); chk("R7 low bits unwritable", r, 32'h0020_0000);
    wr(14, 32'h8000_0000); settle(); chk("R7 soft n15", lvl(1), 32'd15);
    wr(13, 32'h8000_0000); settle(); chk("R7 clear n15", lvl(1), 32'd5);
    wr(13, 32'hFFFF_FFFF); settle(); chk("R7 clear all", lvl(1), 32'd0);
    rd(12, r); chk("R7 pending empty", r, 32'h0);

    // R8 private timer
    @(negedge clk_i); tick_i[3] = 1'b1; settle();
    chk("R8 timer cpu3", lvl(3), 32'd14);
    chk("R8 timer not on cpu0", lvl(0), 32'd0);
    rd(20, r); chk("R8 timer bit7", r, 32'h0000_0080);
    @(negedge clk_i); tick_i[3] = 1'b0; settle();

    // R9 soft write and timer rise in the same cycle on CPU 0
    @(negedge clk_i);
    we_i = 1'b1; addr_i = AW'(10); wdata_i = 32'h0008_0000; tick_i[0] = 1'b1;
    @(posedge clk_i); #1 we_i = 1'b0;
    settle(); chk("R9 concurrent max", lvl(0), 32'd14);
    @(negedge clk_i); tick_i[0] = 1'b0; settle();
    chk("R9 soft remains", lvl(0), 32'd3);
    wr(4, 32'd0);
    src_i = 32'h4000_0000; settle();
    chk("R9 shared above soft", lvl(0), 32'd15);
    src_i = 32'h0; settle();
    chk("R9 back to soft", lvl(0), 32'd3);

    // R4 master mask
    @(negedge clk_i); tick_i[1] = 1'b1; src_i = 32'h0004_0000;
    wr(3, 32'h8000_0000); settle();
    for (int c = 0; c < NCPU; c++) chk("R4 master blocks", lvl(c), 32'd0);
    wr(2, 32'h8000_0000); settle();
    chk("R4 release cpu0", lvl(0), 32'd4);
    chk("R4 release cpu1", lvl(1), 32'd14);
    @(negedge clk_i); tick_i = '0; src_i = 32'h0;

    // R10 write-only and unmapped words
    rd(2, r);  chk("R10 mask clear port reads 0", r, 32'h0);
    rd(3, r);  chk("R10 mask set port reads 0", r, 32'h0);
    rd(5, r);  chk("R10 unmapped 5", r, 32'h0);
    rd(10, r); chk("R10 cpu set port reads 0", r, 32'h0);
    rd(11, r); chk("R10 cpu gap", r, 32'h0);
    rd(31, r); chk("R10 unmapped 31", r, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule